// File: doc/BRIEF.md
# Transmit Interframe Deferral Controller

This block decides when a MAC may start sending a frame. A transmit request is held inside the block until the spacing rules for the selected duplex mode are met. The block then issues a one-clock go strobe and raises a busy flag. The flag stays high until the serializer reports end of frame. All timing is in serial clocks, and one serial clock carries four bit-times.

The two modes space frames differently.

- **Full-duplex:** carrier sense is ignored. The only rule is an idle spacing of 28 clocks (112 bit-times), measured from the clock where the busy flag drops.
- **Half-duplex:** the block waits while carrier is present. Carrier must then stay absent for 16 clocks in a row; carrier inside that window restarts it. After the window, a further 8 clocks run out regardless of carrier. Frames therefore start 96 bit-times after the line goes quiet.

Preamble, data, collisions and backoff are handled elsewhere.

Top module: `txdefer_top`

## Requirements
- R1: After reset, `txBusy` and `goStrobe` are both low.
- R2: In full-duplex mode with a request pending, `txBusy` stays low for exactly 28 clocks after the clock edge that ends a frame, and `goStrobe` appears on the 28th.
- R3: In full-duplex mode, `carrierSense` has no effect on when `goStrobe` appears.
- R4: In full-duplex mode, a request sampled before the gap has run out is held and served when the gap completes. A request sampled after the gap has completed gets `goStrobe` one clock after it is sampled.
- R5: After reset, the full-duplex gap counts as already met, so a request gets `goStrobe` one clock after it is sampled.
- R6: In half-duplex mode, no `goStrobe` is issued while `carrierSense` is high.
- R7: In half-duplex mode, `goStrobe` is registered at the 24th clock edge that samples carrier low, counting from the first edge that samples it low. These 24 edges are a 16-clock quiet window followed by an 8-clock tail. After reset the quiet window is still applied: a request sampled with carrier low gets `goStrobe` 25 edges after it is sampled, counting the sampling edge.
- R8: In half-duplex mode, a clock with `carrierSense` high inside the 16-clock quiet window restarts that window from zero.
- R9: In half-duplex mode, `carrierSense` high during the 8-clock tail does not delay `goStrobe`.
- R10: `goStrobe` is high for exactly one clock, and only in the clock where `txBusy` rises.
- R11: `txBusy` stays high until `frameDone` is sampled high, and is low from the following clock.
- R12: `frameDone` while idle does nothing. `startReq` while `txBusy` is high is dropped: no later `goStrobe` results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to send a frame, sampled while idle |
| fullDuplex | input | 1 | 1 = full-duplex spacing, 0 = half-duplex deferral |
| carrierSense | input | 1 | Carrier present on the medium |
| frameDone | input | 1 | End-of-frame indication from the serializer |
| goStrobe | output | 1 | One-clock permission to begin the frame |
| txBusy | output | 1 | High from go until end of frame |

## Verification
The assertions assume that `fullDuplex` is held steady from a request until its go strobe. They also assume that a change from half-duplex to full-duplex is followed by at least 28 idle clocks. The full-duplex spacing check measures idle time from the previous frame and does not know which mode produced that frame. The stimulus changes mode only while the block is idle. Every full-duplex request comes after a completed frame or after reset, so the spacing rule always applies. Half-duplex carrier patterns are random only over a bounded prefix and then go quiet, so every request finishes.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_QUIET,
    ST_TAIL,
    ST_BUSY
  } deferState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic clrGap;
  } cntCtrl_t;

endpackage

// File: rtl/txdefer_counters.sv
module txdefer_counters
  import txdefer_pkg::*;
#(
  parameter int QUIET_CLKS  = 16,
  parameter int TAIL_CLKS   = 8,
  parameter int FD_GAP_CLKS = 28
) (
  input  logic     clk,
  input  logic     rstN,
  input  cntCtrl_t ctrl,
  output logic     quietDone,
  output logic     tailDone,
  output logic     gapMet
);

  localparam int SPAN = (QUIET_CLKS > TAIL_CLKS) ? QUIET_CLKS : TAIL_CLKS;
  localparam int CW = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam int GW = $clog2(FD_GAP_CLKS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(FD_GAP_CLKS - 1);

  logic [CW-1:0] phaseCnt;
  logic [GW-1:0] gapCnt;

  // Phase counter: shared by the quiet window and the tail.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctrl.clrCnt) begin
      phaseCnt <= '0;
    end else if (ctrl.incCnt) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // Gap counter: saturates once the full-duplex spacing is met; reset starts it met.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= GAP_LAST;
    end else if (ctrl.clrGap) begin
      gapCnt <= '0;
    end else if (gapCnt != GAP_LAST) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assign quietDone = (phaseCnt == CW'(QUIET_CLKS - 1));
  assign tailDone  = (phaseCnt == CW'(TAIL_CLKS - 1));
  assign gapMet    = (gapCnt == GAP_LAST);

endmodule

// File: rtl/txdefer_fsm.sv
module txdefer_fsm
  import txdefer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     fullDuplex,
  input  logic     carrierSense,
  input  logic     frameDone,
  input  logic     quietDone,
  input  logic     tailDone,
  input  logic     gapMet,
  output cntCtrl_t ctrl,
  output logic     goStrobe,
  output logic     txBusy
);

  deferState_t state, stateNext;
  logic goNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    goNext    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNext   = ST_QUIET;
          ctrl.clrCnt = 1'b1;
        end
      end
      ST_QUIET: begin
        if (fullDuplex) begin
          ctrl.clrCnt = 1'b1;
          if (gapMet) begin
            stateNext = ST_BUSY;
            goNext    = 1'b1;
          end
        end else if (carrierSense) begin
          ctrl.clrCnt = 1'b1;
        end else if (quietDone) begin
          stateNext   = ST_TAIL;
          ctrl.clrCnt = 1'b1;
        end else begin
          ctrl.incCnt = 1'b1;
        end
      end
      ST_TAIL: begin
        if (fullDuplex) begin
          stateNext   = ST_QUIET;
          ctrl.clrCnt = 1'b1;
        end else if (tailDone) begin
          stateNext = ST_BUSY;
          goNext    = 1'b1;
        end else begin
          ctrl.incCnt = 1'b1;
        end
      end
      ST_BUSY: begin
        if (frameDone) begin
          stateNext   = ST_IDLE;
          ctrl.clrGap = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      goStrobe <= 1'b0;
    end else begin
      state    <= stateNext;
      goStrobe <= goNext;
    end
  end

  assign txBusy = (state == ST_BUSY);

endmodule

// File: rtl/txdefer_top.sv
module txdefer_top
  import txdefer_pkg::*;
#(
  parameter int QUIET_CLKS  = 16,
  parameter int TAIL_CLKS   = 8,
  parameter int FD_GAP_CLKS = 28
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic fullDuplex,
  input  logic carrierSense,
  input  logic frameDone,
  output logic goStrobe,
  output logic txBusy
);

  cntCtrl_t ctrl;
  logic quietDone, tailDone, gapMet;

  txdefer_fsm u_fsm (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fullDuplex(fullDuplex),
    .carrierSense(carrierSense), .frameDone(frameDone),
    .quietDone(quietDone), .tailDone(tailDone), .gapMet(gapMet),
    .ctrl(ctrl), .goStrobe(goStrobe), .txBusy(txBusy)
  );

  txdefer_counters #(
    .QUIET_CLKS(QUIET_CLKS), .TAIL_CLKS(TAIL_CLKS), .FD_GAP_CLKS(FD_GAP_CLKS)
  ) u_cnt (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .quietDone(quietDone), .tailDone(tailDone), .gapMet(gapMet)
  );

endmodule

// File: rtl/txdefer_checks.sv
module txdefer_checks #(
  parameter int FD_GAP_CLKS = 28
) (
  input logic clk,
  input logic rstN,
  input logic fullDuplex,
  input logic frameDone,
  input logic goStrobe,
  input logic txBusy
);

  localparam int IW = $clog2(FD_GAP_CLKS + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(FD_GAP_CLKS);

  // Idle clocks seen since busy last dropped; starts saturated after reset.
  logic [IW-1:0] idleRun;
  always_ff @(posedge clk) begin
    if (!rstN)                   idleRun <= IDLE_MAX;
    else if (txBusy)             idleRun <= '0;
    else if (idleRun != IDLE_MAX) idleRun <= idleRun + 1'b1;
  end

  assert_go_with_busy_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    goStrobe |-> (txBusy && !$past(txBusy)));

  assert_go_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    goStrobe |=> !goStrobe);

  assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !frameDone) |=> txBusy);

  assert_busy_drops_R11: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && frameDone) |=> !txBusy);

  assert_fd_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (goStrobe && fullDuplex) |-> (idleRun >= IDLE_MAX));

endmodule

bind txdefer_top txdefer_checks #(.FD_GAP_CLKS(FD_GAP_CLKS)) u_checks (
  .clk(clk), .rstN(rstN), .fullDuplex(fullDuplex), .frameDone(frameDone),
  .goStrobe(goStrobe), .txBusy(txBusy)
);

// File: tb/txdefer_top_test.sv
module txdefer_top_test;

  localparam int QUIET = 16;
  localparam int TAIL  = 8;
  localparam int FDGAP = 28;
  localparam int PATN  = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic fullDuplex = 1'b1;
  logic carrierSense = 1'b0;
  logic frameDone = 1'b0;
  logic goStrobe, txBusy;

  int vectors = 0;
  int misses = 0;
  logic pat [PATN];

  always #4 clk = ~clk;

  txdefer_top uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fullDuplex(fullDuplex),
    .carrierSense(carrierSense), .frameDone(frameDone),
    .goStrobe(goStrobe), .txBusy(txBusy)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Edges to go, counting the request-sampling edge, full-duplex after d idle waits.
  function automatic int fdExpect(input int d, input bit fresh);
    if (fresh) return 2;
    return (FDGAP - d > 2) ? FDGAP - d : 2;
  endfunction

  // Edges to go in half-duplex: pat[k] is carrier as sampled at edge k after request.
  function automatic int hdExpect();
    int cnt = 0;
    bit inTail = 0;
    for (int k = 1; k < PATN; k++) begin
      if (!inTail) begin
        if (pat[k]) cnt = 0;
        else if (cnt == QUIET - 1) begin inTail = 1; cnt = 0; end
        else cnt++;
      end else begin
        if (cnt == TAIL - 1) return k + 1;
        cnt++;
      end
    end
    return -1;
  endfunction

  task automatic runReq(output int n);
    n = -1;
    startReq = 1'b1;
    carrierSense = pat[0];
    for (int k = 0; k < PATN - 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      startReq = 1'b0;
      if (goStrobe) begin n = k + 1; break; end
      carrierSense = pat[k + 1];
    end
    startReq = 1'b0;
  endtask

  task automatic holdFrame(input int h, input bit poke);
    check("R10 busy with go", int'(txBusy), 1);
    for (int i = 0; i < h; i++) begin
      startReq = poke && (i == 0);
      @(negedge clk);
      check("R10 go single clock", int'(goStrobe), 0);
      check("R11 busy held", int'(txBusy), 1);
    end
    startReq = 1'b0;
  endtask

  task automatic finishFrame();
    frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
    check("R11 busy drops", int'(txBusy), 0);
  endtask

  task automatic fillRandom(input int lim, input int oneIn);
    for (int i = 0; i < PATN; i++) pat[i] = (i < lim) && ($urandom % oneIn == 0);
  endtask

  int n, d, e;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 busy after reset", int'(txBusy), 0);
    check("R1 go after reset", int'(goStrobe), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R12: end-of-frame while idle does nothing
    frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R12 idle frameDone busy", int'(txBusy), 0);
      check("R12 idle frameDone go", int'(goStrobe), 0);
    end

    // R5: fresh full-duplex, carrier high ignored
    fullDuplex = 1'b1;
    for (int i = 0; i < PATN; i++) pat[i] = 1'b1;
    runReq(n);
    check("R5 fresh full-duplex", n, fdExpect(0, 1));
    holdFrame(4, 1);            // request during busy is dropped (R12)
    finishFrame();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R12 busy request dropped", int'(goStrobe), 0);
    end

    // R2: back-to-back full-duplex, request right after frame end
    fillRandom(0, 2);
    runReq(n);
    holdFrame(3, 0);
    finishFrame();
    runReq(n);
    check("R2 full-duplex gap", n, FDGAP);
    holdFrame(2, 0);
    finishFrame();

    // R7: half-duplex with quiet line
    repeat (30) @(negedge clk);
    fullDuplex = 1'b0;
    fillRandom(0, 2);
    runReq(n);
    check("R7 half-duplex quiet line", n, 1 + QUIET + TAIL);
    holdFrame(2, 0);
    finishFrame();

    // R6: carrier held for 60 clocks
    for (int i = 0; i < PATN; i++) pat[i] = (i <= 60);
    runReq(n);
    check("R6 defer during carrier", n, 61 + QUIET + TAIL);
    holdFrame(2, 0);
    finishFrame();

    // R8: carrier blip inside quiet window restarts it
    for (int i = 0; i < PATN; i++) pat[i] = (i <= 5) || (i == 16);
    runReq(n);
    check("R8 quiet window restart", n, 41);
    holdFrame(2, 0);
    finishFrame();

    // R9: carrier during tail ignored
    for (int i = 0; i < PATN; i++) pat[i] = (i >= 18) && (i <= 22);
    runReq(n);
    check("R9 tail ignores carrier", n, 25);
    holdFrame(2, 0);
    finishFrame();

    // Random mix of modes, delays and carrier patterns
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 2 == 0) begin
        repeat (FDGAP + 2) @(negedge clk);
        fullDuplex = 1'b1;
        // re-establish a frame end so the gap is measured from it
        for (int i = 0; i < PATN; i++) pat[i] = 1'b0;
        runReq(n);
        holdFrame(1, 0);
        finishFrame();
        d = $urandom % 40;
        for (int i = 0; i < d; i++) begin
          carrierSense = $urandom % 2;
          @(negedge clk);
        end
        fillRandom(PATN, 2);
        runReq(n);
        check("R4 held request / R3 carrier ignored", n, fdExpect(d, 0));
      end else begin
        fullDuplex = 1'b0;
        repeat ($urandom % 5) @(negedge clk);
        fillRandom(30, 4);
        e = hdExpect();
        runReq(n);
        check("R7 half-duplex random carrier", n, e);
      end
      holdFrame(1 + $urandom % 6, $urandom % 2);
      finishFrame();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule